// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block copies a contiguous run of 32-bit words between a 32-entry register file and a word-wide memory port. One start command supplies the direction, the first register index, a byte base address and an endian select. The run always ends at the highest register. So the start index alone sets how many words move: index 31 moves one word and index 0 moves thirty-two.

Each word is a single memory transaction under a valid/ready handshake. A load also waits for a separate read-response strobe before it writes the register file. In little-endian mode the byte order of every word is reversed on its way through the block, in both directions. A base address that is not word aligned is rejected with a one-cycle error flag. A pulse on `done` marks the end of a good run.

Top module: `word_run_mover`

## Requirements
- R1: After reset `busy`, `done`, `align_err`, `mem_valid` and `rf_we` are all low.
- R2: An accepted run moves exactly one word per register from `start_reg` up to 31 inclusive: 32 - `start_reg` memory handshakes (`mem_valid` and `mem_ready` both high).
- R3: The k-th handshake of a run (k counted from 0) carries byte address `start_addr` + 4k. `mem_we` is 0 for a load (`start_load`=1) and 1 for a store.
- R4: In a load, register `start_reg`+k receives the k-th response word. `rf_we` is high only in a cycle where `mem_rvalid` is high.
- R5: In a store, the word at address `start_addr`+4k receives the value of register `start_reg`+k.
- R6: With `start_le`=1 every moved word is byte-reversed on both paths: bits 7:0 swap with bits 31:24, and bits 15:8 swap with bits 23:16. With `start_le`=0 words pass unchanged.
- R7: While `mem_valid` is high and `mem_ready` is low, the block keeps `mem_valid` high and holds `mem_addr`, `mem_we` and `mem_wdata` stable into the next cycle.
- R8: A start whose `start_addr` has bits 1:0 nonzero raises `align_err` for exactly the next cycle. It performs no handshake and leaves `busy` low.
- R9: `done` is high for exactly one cycle: the cycle after the final store handshake or final load response. `busy` is low in that cycle.
- R10: A `start` pulse while `busy` is high is ignored. The run in progress completes with its own parameters, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command strobe |
| start_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| start_reg | input | 5 | First register index |
| start_addr | input | 32 | Base byte address |
| start_le | input | 1 | Byte-reverse every word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| align_err | output | 1 | One-cycle misaligned-base pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The hardest case to reach is a long run in which back-pressure and response latency interleave irregularly. Under that stimulus a request must hold still for several cycles, and a load must not write its register before the response arrives. The bench memory model drops `mem_ready` and delays `mem_rvalid` at random, cycle by cycle, from a fixed seed. Random runs of mixed direction, start index and endian mode, plus directed runs from indices 0 and 31, cover both short and full-length runs under that pressure. A second start issued partway through a stalled run shows that commands are ignored while busy.

// File: rtl/word_run_mover.sv
module word_run_mover #(
  parameter int REGS   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(REGS),
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_load,
  input  logic [IDX_W-1:0]  start_reg,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_le,
  output logic              busy,
  output logic              done,
  output logic              align_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RESP} st_t;

  st_t              st;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr;
  logic              is_load, le, done_q, err_q;
  logic [DATA_W-1:0] wr_rev, rd_rev;

  for (genvar b = 0; b < BYTES; b++) begin : g_rev
    assign wr_rev[8*b +: 8] = rf_rdata[8*(BYTES-1-b) +: 8];
    assign rd_rev[8*b +: 8] = mem_rdata[8*(BYTES-1-b) +: 8];
  end

  wire misaligned = start_addr[OFS_W-1:0] != '0;
  wire last       = idx == IDX_W'(REGS - 1);
  wire finish     = (st == S_REQ && mem_ready && !is_load) ||
                    (st == S_RESP && mem_rvalid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      addr    <= '0;
      is_load <= 1'b0;
      le      <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (misaligned) err_q <= 1'b1;
            else begin
              st      <= S_REQ;
              idx     <= start_reg;
              addr    <= start_addr;
              is_load <= start_load;
              le      <= start_le;
            end
          end
        S_REQ:
          if (mem_ready && is_load) st <= S_RESP;
        default: ;
      endcase
      if (finish) begin
        if (last) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          st   <= S_REQ;
          idx  <= idx + 1'b1;
          addr <= addr + ADDR_W'(BYTES);
        end
      end
    end
  end

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign align_err = err_q;
  assign mem_valid = st == S_REQ;
  assign mem_we    = !is_load;
  assign mem_addr  = addr;
  assign mem_wdata = le ? wr_rev : rf_rdata;
  assign rf_raddr  = idx;
  assign rf_we     = st == S_RESP && mem_rvalid;
  assign rf_waddr  = idx;
  assign rf_wdata  = le ? rd_rev : mem_rdata;
endmodule

// File: rtl/word_run_mover_chk.sv
module word_run_mover_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              align_err,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rvalid,
  input logic              rf_we
);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_write_on_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_rvalid);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_no_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !busy && !mem_valid);

  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !rf_we);
endmodule

bind word_run_mover word_run_mover_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .align_err(align_err),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .rf_we(rf_we)
);

// File: tb/tb_word_run_mover.sv
module tb_word_run_mover;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, start_load = 0, start_le = 0;
  logic [4:0]  start_reg = 0;
  logic [31:0] start_addr = 0;
  logic        busy, done, align_err, mem_valid, mem_we, rf_we;
  logic        mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [4:0]  rf_raddr, rf_waddr;

  always #5 clk = ~clk;

  word_run_mover dut (.*);

  logic [31:0] mem [256];
  logic [31:0] rf  [32];
  logic [31:0] exp_mem [256];
  logic [31:0] exp_rf  [32];
  logic        pend = 0;
  logic [31:0] pdata = 0;
  int          hs_cnt = 0, hs_base = 0, addr_checks = 0, addr_fails = 0;
  logic [31:0] exp_base = 0;
  logic        exp_we = 0;
  int          checks = 0, fails = 0;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = pdata;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_rvalid) pend <= 1'b0;
    if (mem_valid && mem_ready) begin
      addr_checks++;
      if (mem_addr !== exp_base + 32'(4 * (hs_cnt - hs_base)) || mem_we !== exp_we) begin
        addr_fails++;
        $display("FAIL R3: handshake %0d addr=%h we=%b expected addr=%h we=%b",
                 hs_cnt - hs_base, mem_addr, mem_we,
                 exp_base + 32'(4 * (hs_cnt - hs_base)), exp_we);
      end
      hs_cnt++;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else begin
        pend  <= 1'b1;
        pdata <= mem[mem_addr[9:2]];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      mem_ready  <= ($urandom % 3) != 0;
      mem_rvalid <= pend && ($urandom % 2 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic run(input bit ld, input logic [4:0] sreg, input logic [31:0] base,
                     input bit le, input bit poke);
    int n, w, cyc;
    n = 32 - int'(sreg);
    w = int'(base[9:2]);
    foreach (rf[i]) exp_rf[i] = rf[i];
    foreach (mem[i]) exp_mem[i] = mem[i];
    for (int k = 0; k < n; k++) begin
      if (ld) exp_rf[int'(sreg) + k] = le ? bswap(mem[w + k]) : mem[w + k];
      else exp_mem[w + k] = le ? bswap(rf[int'(sreg) + k]) : rf[int'(sreg) + k];
    end
    @(negedge clk);
    hs_base = hs_cnt; exp_base = base; exp_we = !ld;
    start = 1; start_load = ld; start_reg = sreg; start_addr = base; start_le = le;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      if (poke && cyc == 3) begin
        start = 1; start_load = !ld; start_reg = 0; start_addr = base + 32'd64; start_le = !le;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    check(done === 1'b1, "R9", "done seen", 32'(done), 32'd1);
    check(busy === 1'b0, "R9", "busy at done", 32'(busy), 32'd0);
    check(hs_cnt - hs_base == n, "R2", "handshake count", 32'(hs_cnt - hs_base), 32'(n));
    begin
      int bad = 0;
      foreach (rf[i]) if (rf[i] !== exp_rf[i]) bad++;
      check(bad == 0, ld ? (le ? "R4/R6" : "R4") : "R10", "register file mismatches", 32'(bad), 0);
      bad = 0;
      foreach (mem[i]) if (mem[i] !== exp_mem[i]) bad++;
      check(bad == 0, ld ? "R10" : (le ? "R5/R6" : "R5"), "memory mismatches", 32'(bad), 0);
    end
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle", 32'(done), 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      check(!busy && hs_cnt - hs_base == n, "R10", "no run after ignored start",
            32'(hs_cnt - hs_base), 32'(n));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    foreach (rf[i]) rf[i] = $urandom;
    foreach (mem[i]) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    check(!busy && !done && !align_err && !mem_valid && !rf_we, "R1", "idle outputs",
          {27'd0, busy, done, align_err, mem_valid, rf_we}, 0);
    rst_n = 1;
    @(negedge clk);
    start = 1; start_load = 1; start_reg = 4; start_addr = 32'h0000_0042; start_le = 0;
    hs_base = hs_cnt;
    @(negedge clk);
    start = 0;
    check(align_err === 1'b1 && busy === 1'b0, "R8", "misaligned start flag", 32'(align_err), 1);
    @(negedge clk);
    check(align_err === 1'b0, "R8", "flag one cycle", 32'(align_err), 0);
    repeat (5) @(negedge clk);
    check(hs_cnt == hs_base && !busy, "R8", "no transfer on misaligned", 32'(hs_cnt - hs_base), 0);

    run(1, 5'd31, 32'h0000_0010, 0, 0);
    run(0, 5'd31, 32'h0000_0020, 1, 0);
    run(1, 5'd0,  32'h0000_0100, 1, 0);
    run(0, 5'd0,  32'h0000_0200, 0, 0);
    run(0, 5'd8,  32'h0000_0040, 0, 1);
    run(1, 5'd2,  32'h0000_0080, 1, 1);
    for (int t = 0; t < 24; t++)
      run($urandom % 2, 5'($urandom), {22'd0, 8'($urandom % 200), 2'b00}, $urandom % 2, 0);

    checks += addr_checks;
    fails  += addr_fails;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    checks++; fails++;
    $display("FAIL watchdog: run did not end actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + addr_checks, fails + addr_fails);
    $finish;
  end
endmodule